// File: doc/BRIEF.md
# Single-Wire Sync Line Codec

This block sits on a shared open-drain line with a pull-up. The line carries the switching clock from one master converter to all its slaves. The same block serves both roles. It acts as master when its phase-mode input and all five phase-select inputs are low, and as a slave otherwise. As master it pulls the line low once per line period. The low time carries a symbol: a quarter of the period means a sync symbol, and three quarters of the period means a data-zero symbol. The symbol for each period comes from `sym_tx_i`, sampled at the start of that period.

The receive side works in both roles, so a master also decodes its own line. Clock recovery uses counters running on a fast system clock instead of an analog loop. The receiver synchronises the sensed line level and issues a one-cycle tick on every falling edge. At each falling edge it measures the low time and the edge-to-edge period of the previous line period. It classifies that period as sync or data zero. It flags the symbol as an error when the period is outside the accepted frequency range or the low time is outside its tolerance window. A line that stays without a falling edge for one and a half nominal periods raises loss-of-sync.

The transmit state machine has three states:
- `M_IDLE`: not master, not driving.
- `M_LOW`: driving the line low.
- `M_HIGH`: line released for the rest of the period.

Its transitions are:
- start, from `M_IDLE` to `M_LOW`, taken when master mode is selected.
- width-done, from `M_LOW` to `M_HIGH`.
- period-end, from `M_HIGH` back to `M_LOW`, which latches the next symbol.
- release, from any state to `M_IDLE`, taken when master mode is dropped.

The receive state machine has three states:
- `D_HUNT`: no timing reference; loss-of-sync is high.
- `D_LOW`: measuring the low time.
- `D_HIGH`: waiting for the next fall.

Its transitions are:
- acquire, from `D_HUNT` to `D_LOW` on a fall.
- rise, from `D_LOW` to `D_HIGH`.
- next-fall, from `D_HIGH` to `D_LOW`, which emits a symbol.
- timeout, from `D_LOW` or `D_HIGH` to `D_HUNT`.

Top module: `sync_line_codec`

## Requirements
- R1: After reset the line is not driven, loss-of-sync is 1, and tick, symbol-valid, symbol and error are all 0.
- R2: The block drives the line only while `phase_mode_i` is 0 and `phase_sel_i` is all zeros. Whenever that condition is false at a clock edge, `line_pull_low_o` is 0 after that edge.
- R3: As master, `line_pull_low_o` rises in the cycle after master mode is first seen and repeats every PERIOD_CYC cycles (100 by default). Each period's low time is PERIOD_CYC/4 cycles when `sym_tx_i` is 0 (sync) and 3*PERIOD_CYC/4 cycles when it is 1 (data zero). `sym_tx_i` is sampled in the edge that starts the period.
- R4: Each high-to-low transition of `line_i` gives a one-cycle `tick_o`. The tick appears after the third rising clock edge that samples the line low, because the path is two synchroniser flops plus one output register.
- R5: At a fall that follows an earlier fall with no loss in between, `sym_valid_o` is asserted with the tick. `sym_o` is 1 (data zero) when twice the measured low time is at least the measured period, and 0 (sync) otherwise. The low time and period are counted in clock cycles between sampled edges.
- R6: `sym_err_o` is asserted with a valid symbol in two cases. The first is a period outside PER_MIN_CYC..PER_MAX_CYC (95..106 by default). The second is a low time outside 22%..28% of the period for sync, or outside 72%..78% for data zero.
- R7: When LOS_CYC = 3*PERIOD_CYC/2 cycles pass since the last sampled fall with no new fall, `lost_o` rises. The next fall clears `lost_o` together with its tick, and that fall emits no symbol.
- R8: A fall sampled exactly LOS_CYC cycles after the previous one counts as in time. It emits a symbol (flagged as an error for its period), and `lost_o` stays 0.
- R9: In master mode the receiver decodes the block's own line, giving the same ticks and symbols a slave would see.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, PERIOD_CYC cycles per nominal line period |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_mode_i | input | 1 | Phase-mode strap; 0 together with all-zero phase_sel_i selects master |
| phase_sel_i | input | SEL_W | Phase-select straps |
| sym_tx_i | input | 1 | Symbol to send as master: 0 sync, 1 data zero |
| line_i | input | 1 | Sensed level of the shared line |
| line_pull_low_o | output | 1 | 1 pulls the shared line low |
| tick_o | output | 1 | Recovered clock strobe, one cycle per falling edge |
| sym_valid_o | output | 1 | A decoded symbol is present |
| sym_o | output | 1 | Decoded symbol: 0 sync, 1 data zero |
| sym_err_o | output | 1 | Decoded symbol out of tolerance |
| lost_o | output | 1 | Loss-of-sync |

## Verification
Two receive events can land on the same clock edge: the loss timeout and the arrival of a falling edge. The bench provokes this with a pulse whose falling edges are exactly LOS_CYC cycles apart, and with a second pulse one cycle longer. The first case must yield a valid symbol carrying an error and no rise of loss-of-sync. The second must raise loss-of-sync and then emit no symbol on the next fall. A behavioural model, kept as integer edge indices and a sample history, predicts every output on every cycle, and explicit counts confirm that both outcomes were reached.

// File: rtl/sync_line_pkg.sv
package sync_line_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_LOW  = 2'd1,
        M_HIGH = 2'd2
    } mstate_t;

    typedef enum logic [1:0] {
        D_HUNT = 2'd0,
        D_LOW  = 2'd1,
        D_HIGH = 2'd2
    } dstate_t;

    typedef enum logic {
        SYM_SYNC  = 1'b0,
        SYM_DATA0 = 1'b1
    } sym_t;

    // True when width lies within [lo_pct, hi_pct] percent of period.
    function automatic logic pct_within(input int unsigned width,
                                        input int unsigned period,
                                        input int unsigned lo_pct,
                                        input int unsigned hi_pct);
        return (width * 100 >= period * lo_pct) && (width * 100 <= period * hi_pct);
    endfunction

endpackage

// File: rtl/sync_line_sync.sv
module sync_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic fall_o,
    output logic rise_o
);

    // sh[0] is the newest sample; sh[STAGES] holds the previous synchronised level.
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-1:0], line_i};
        end
    end

    assign line_s_o = sh[STAGES-1];
    assign fall_o   = sh[STAGES] & ~sh[STAGES-1];
    assign rise_o   = ~sh[STAGES] & sh[STAGES-1];

endmodule

// File: rtl/sync_master_gen.sv
module sync_master_gen
    import sync_line_pkg::*;
#(
    parameter int PERIOD_CYC = 100,
    parameter int SEL_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_mode_i,
    input  logic [SEL_W-1:0] phase_sel_i,
    input  logic             sym_tx_i,
    output logic             drive_o
);

    localparam int PW     = $clog2(PERIOD_CYC + 1);
    localparam int SYNC_W = PERIOD_CYC / 4;
    localparam int DATA_W = (3 * PERIOD_CYC) / 4;
    localparam logic [PW-1:0] PER_C  = PW'(PERIOD_CYC);
    localparam logic [PW-1:0] SYNC_C = PW'(SYNC_W);
    localparam logic [PW-1:0] DATA_C = PW'(DATA_W);

    mstate_t         state, nxt;
    logic [PW-1:0]   pc;
    logic [PW-1:0]   width;
    logic            is_master;
    logic            start;

    assign is_master = !phase_mode_i && (phase_sel_i == '0);
    assign start     = is_master &&
                       ((state == M_IDLE) || (state == M_HIGH && pc == PER_C));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= M_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic: start, width-done, period-end, release
    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE: nxt = is_master ? M_LOW : M_IDLE;
            M_LOW:  begin
                if (!is_master)        nxt = M_IDLE;
                else if (pc == width)  nxt = M_HIGH;
                else                   nxt = M_LOW;
            end
            M_HIGH: begin
                if (!is_master)        nxt = M_IDLE;
                else if (pc == PER_C)  nxt = M_LOW;
                else                   nxt = M_HIGH;
            end
            default: nxt = M_IDLE;
        endcase
    end

    // Period counter and symbol latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            width <= SYNC_C;
        end else if (start) begin
            pc    <= PW'(1);
            width <= sym_tx_i ? DATA_C : SYNC_C;
        end else if (state != M_IDLE) begin
            pc    <= pc + PW'(1);
        end
    end

    // Output logic
    always_comb begin
        drive_o = (state == M_LOW);
    end

endmodule

// File: rtl/sync_pulse_decoder.sv
module sync_pulse_decoder
    import sync_line_pkg::*;
#(
    parameter int PERIOD_CYC   = 100,
    parameter int PER_MIN_CYC  = 95,
    parameter int PER_MAX_CYC  = 106,
    parameter int SYNC_MIN_PCT = 22,
    parameter int SYNC_MAX_PCT = 28,
    parameter int DATA_MIN_PCT = 72,
    parameter int DATA_MAX_PCT = 78
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s_i,
    input  logic fall_i,
    input  logic rise_i,
    output logic tick_o,
    output logic sym_valid_o,
    output logic sym_o,
    output logic sym_err_o,
    output logic lost_o
);

    localparam int LOS_CYC = (3 * PERIOD_CYC) / 2;
    localparam int CW      = $clog2(LOS_CYC + 2);
    localparam logic [CW-1:0] LOS_C  = CW'(LOS_CYC);
    localparam logic [CW-1:0] PMIN_C = CW'(PER_MIN_CYC);
    localparam logic [CW-1:0] PMAX_C = CW'(PER_MAX_CYC);

    dstate_t        state, nxt;
    logic [CW-1:0]  since;
    logic [CW-1:0]  low_w;
    logic           timeout;
    logic           emit;
    logic           is_data;
    logic           per_ok;
    logic           wid_ok;

    assign timeout = (since >= LOS_C);
    assign emit    = fall_i && (state == D_HIGH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= D_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic: acquire, rise, next-fall, timeout
    always_comb begin
        nxt = state;
        unique case (state)
            D_HUNT: nxt = fall_i ? D_LOW : D_HUNT;
            D_LOW:  begin
                if (timeout)      nxt = D_HUNT;
                else if (rise_i)  nxt = D_HIGH;
                else              nxt = D_LOW;
            end
            D_HIGH: begin
                if (fall_i)       nxt = D_LOW;
                else if (timeout) nxt = D_HUNT;
                else              nxt = D_HIGH;
            end
            default: nxt = D_HUNT;
        endcase
    end

    // Edge-to-edge and low-time counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
            low_w <= '0;
        end else if (fall_i) begin
            since <= CW'(1);
            low_w <= CW'(1);
        end else if (state != D_HUNT) begin
            if (!(&since)) since <= since + CW'(1);
            if (state == D_LOW && !line_s_i && !(&low_w)) low_w <= low_w + CW'(1);
        end
    end

    // Classification of the period just closed
    always_comb begin
        is_data = ({1'b0, low_w} << 1) >= {1'b0, since};
        per_ok  = (since >= PMIN_C) && (since <= PMAX_C);
        if (is_data) begin
            wid_ok = pct_within(32'(low_w), 32'(since), DATA_MIN_PCT, DATA_MAX_PCT);
        end else begin
            wid_ok = pct_within(32'(low_w), 32'(since), SYNC_MIN_PCT, SYNC_MAX_PCT);
        end
    end

    // Registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_o      <= 1'b0;
            sym_valid_o <= 1'b0;
            sym_o       <= SYM_SYNC;
            sym_err_o   <= 1'b0;
        end else begin
            tick_o      <= fall_i;
            sym_valid_o <= emit;
            sym_o       <= emit ? (is_data ? SYM_DATA0 : SYM_SYNC) : SYM_SYNC;
            sym_err_o   <= emit && !(per_ok && wid_ok);
        end
    end

    // Output logic
    always_comb begin
        lost_o = (state == D_HUNT);
    end

endmodule

// File: rtl/sync_line_codec.sv
module sync_line_codec #(
    parameter int PERIOD_CYC  = 100,
    parameter int PER_MIN_CYC = 95,
    parameter int PER_MAX_CYC = 106,
    parameter int SEL_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_mode_i,
    input  logic [SEL_W-1:0] phase_sel_i,
    input  logic             sym_tx_i,
    input  logic             line_i,
    output logic             line_pull_low_o,
    output logic             tick_o,
    output logic             sym_valid_o,
    output logic             sym_o,
    output logic             sym_err_o,
    output logic             lost_o
);

    logic line_s;
    logic fall;
    logic rise;

    sync_master_gen #(
        .PERIOD_CYC (PERIOD_CYC),
        .SEL_W      (SEL_W)
    ) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_mode_i (phase_mode_i),
        .phase_sel_i  (phase_sel_i),
        .sym_tx_i     (sym_tx_i),
        .drive_o      (line_pull_low_o)
    );

    sync_line_sync #(
        .STAGES (2)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .line_s_o (line_s),
        .fall_o   (fall),
        .rise_o   (rise)
    );

    sync_pulse_decoder #(
        .PERIOD_CYC  (PERIOD_CYC),
        .PER_MIN_CYC (PER_MIN_CYC),
        .PER_MAX_CYC (PER_MAX_CYC)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_s_i    (line_s),
        .fall_i      (fall),
        .rise_i      (rise),
        .tick_o      (tick_o),
        .sym_valid_o (sym_valid_o),
        .sym_o       (sym_o),
        .sym_err_o   (sym_err_o),
        .lost_o      (lost_o)
    );

endmodule

// File: rtl/sync_line_codec_chk.sv
module sync_line_codec_chk #(
    parameter int PERIOD_CYC = 100,
    parameter int SEL_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_mode_i,
    input logic [SEL_W-1:0] phase_sel_i,
    input logic             line_pull_low_o,
    input logic             tick_o,
    input logic             sym_valid_o,
    input logic             sym_err_o,
    input logic             lost_o
);

    localparam int DATA_W = (3 * PERIOD_CYC) / 4;
    localparam int RW     = $clog2(PERIOD_CYC + 2);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (line_pull_low_o) begin
            if (!(&low_run)) low_run <= low_run + RW'(1);
        end else begin
            low_run <= '0;
        end
    end

    assert_slave_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!phase_mode_i && phase_sel_i == '0) |=> !line_pull_low_o);

    assert_low_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull_low_o |-> (32'(low_run) < DATA_W));

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_valid_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> tick_o);

    assert_err_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err_o |-> sym_valid_o);

    assert_lost_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost_o) |-> tick_o);

    assert_no_sym_after_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> !$past(lost_o));

endmodule

bind sync_line_codec sync_line_codec_chk #(
    .PERIOD_CYC (PERIOD_CYC),
    .SEL_W      (SEL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .phase_mode_i    (phase_mode_i),
    .phase_sel_i     (phase_sel_i),
    .line_pull_low_o (line_pull_low_o),
    .tick_o          (tick_o),
    .sym_valid_o     (sym_valid_o),
    .sym_err_o       (sym_err_o),
    .lost_o          (lost_o)
);

// File: tb/sync_line_codec_test.sv
module sync_line_codec_test;

    localparam int P    = 100;
    localparam int LOS  = 150;
    localparam int PMIN = 95;
    localparam int PMAX = 106;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       pm = 1'b1;
    logic [4:0] sel = 5'd0;
    logic       stx = 1'b0;
    logic       ext_low = 1'b0;
    wire        line;
    logic       drv, tick, vld, sym, err, lost;

    assign line = ~(drv | ext_low);

    sync_line_codec uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .phase_mode_i    (pm),
        .phase_sel_i     (sel),
        .sym_tx_i        (stx),
        .line_i          (line),
        .line_pull_low_o (drv),
        .tick_o          (tick),
        .sym_valid_o     (vld),
        .sym_o           (sym),
        .sym_err_o       (err),
        .lost_o          (lost)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    bit hist[$];
    int n = 0, k = 0, low = 0;
    bit ref_ok = 0, open = 0;
    bit m_act = 0;
    int m_ph = 0, m_w = 0;
    bit e_drive = 0, e_tick = 0, e_vld = 0, e_sym = 0, e_err = 0, e_lost = 1;

    // observation counters
    int n_vld = 0, n_err = 0, n_drive = 0, n_lost_rise = 0;
    bit prev_lost = 1;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp, input bit at_least);
        tests++;
        if (at_least ? (act < exp) : (act != exp)) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%s%0d", req, what, act, at_least ? ">=" : "", exp);
        end
    endtask

    task automatic model_step(input bit smp, input bit mode, input logic [4:0] s, input bit tx);
        bit is_m, d, p, fall;
        int per;
        // master side (R3, R2)
        is_m = !mode && (s == 5'd0);
        if (!is_m) m_act = 0;
        else if (!m_act) begin m_act = 1; m_ph = 0; m_w = tx ? (3*P)/4 : P/4; end
        else begin
            m_ph++;
            if (m_ph == P) begin m_ph = 0; m_w = tx ? (3*P)/4 : P/4; end
        end
        e_drive = m_act && (m_ph < m_w);
        // receive side (R4..R8)
        hist.push_back(smp);
        n++;
        d = hist[hist.size()-3];
        p = hist[hist.size()-4];
        if (hist.size() > 8) void'(hist.pop_front());
        fall = p && !d;
        e_tick = fall; e_vld = 0; e_sym = 0; e_err = 0;
        if (fall) begin
            if (ref_ok) begin
                per   = n - k;
                e_vld = 1;
                e_sym = (2*low >= per);
                if (per < PMIN || per > PMAX) e_err = 1;
                else if (e_sym) e_err = !(low*100 >= per*72 && low*100 <= per*78);
                else            e_err = !(low*100 >= per*22 && low*100 <= per*28);
            end
            k = n; ref_ok = 1; low = 1; open = 1;
        end else begin
            if (ref_ok && (n - k) >= LOS) ref_ok = 0;
            if (open) begin
                if (!d) low++;
                else    open = 0;
            end
        end
        e_lost = !ref_ok;
    endtask

    task automatic cyc(input bit ext, input bit mode, input logic [4:0] s, input bit tx);
        @(negedge clk);
        check("R3", "drive", drv, e_drive);
        check("R4", "tick", tick, e_tick);
        check("R5", "sym_valid", vld, e_vld);
        check("R5", "sym", sym, e_sym);
        check("R6", "sym_err", err, e_err);
        check("R7", "lost", lost, e_lost);
        if (vld) n_vld++;
        if (err) n_err++;
        if (drv) n_drive++;
        if (lost && !prev_lost) n_lost_rise++;
        prev_lost = lost;
        rst_n = 1'b1;
        ext_low = ext; pm = mode; sel = s; stx = tx;
        #1;
        model_step(line === 1'b1, mode, s, tx);
    endtask

    task automatic pulse(input int lw, input int per);
        for (int i = 0; i < per; i++) cyc(i < lw, 1'b1, 5'd0, 1'b0);
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) cyc(1'b0, 1'b1, 5'd0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v0, e0;
        hist = '{1'b1, 1'b1, 1'b1};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset drive", drv, 1'b0);
        check("R1", "reset lost", lost, 1'b1);
        check("R1", "reset tick", tick, 1'b0);
        check("R1", "reset valid", vld, 1'b0);
        check("R1", "reset err", err, 1'b0);

        idle(10);
        // R5: nominal sync and data-zero symbols
        v0 = n_vld;
        repeat (3) pulse(25, 100);
        repeat (3) pulse(75, 100);
        // tolerance edges that are accepted
        pulse(24, 96);
        pulse(78, 105);
        pulse(25, 100);
        check_int("R5", "symbols decoded", n_vld - v0, 8, 1'b1);
        // R6: width and period out of range
        e0 = n_err;
        pulse(40, 100);
        pulse(60, 100);
        pulse(25, 90);
        pulse(25, 110);
        pulse(25, 100);
        check_int("R6", "error symbols", n_err - e0, 4, 1'b0);

        // R7: loss after silence, recovery without a symbol
        e0 = n_lost_rise;
        idle(200);
        check_int("R7", "loss raised", n_lost_rise - e0, 1, 1'b0);
        v0 = n_vld;
        pulse(25, 100);
        pulse(25, 100);
        idle(3);
        check_int("R7", "symbols after loss", n_vld - v0, 1, 1'b0);

        // R8: fall exactly at the loss limit is in time
        pulse(25, 100);
        e0 = n_lost_rise; v0 = n_err;
        pulse(25, LOS);
        pulse(25, 100);
        check_int("R8", "loss at limit", n_lost_rise - e0, 0, 1'b0);
        check_int("R8", "err at limit", n_err - v0, 1, 1'b0);
        e0 = n_lost_rise;
        pulse(25, LOS + 1);
        pulse(25, 100);
        pulse(25, 100);
        check_int("R8", "loss one past limit", n_lost_rise - e0, 1, 1'b0);

        // R3, R9: master mode with loopback decode
        v0 = n_vld;
        e0 = n_err;
        for (int per = 0; per < 7; per++) begin
            bit tx;
            tx = (per == 1 || per == 2 || per == 4 || per == 6);
            for (int i = 0; i < P; i++) cyc(1'b0, 1'b0, 5'd0, tx);
        end
        check_int("R9", "loopback symbols", n_vld - v0, 5, 1'b1);
        check_int("R9", "loopback errors", n_err - e0, 0, 1'b0);

        // R2: one select bit high keeps the block a slave
        cyc(1'b0, 1'b0, 5'b00100, 1'b0);
        e0 = n_drive;
        for (int i = 0; i < 250; i++) cyc(1'b0, 1'b0, 5'b00100, 1'b1);
        check_int("R2", "slave drive cycles", n_drive - e0, 0, 1'b0);
        // R2: drop master in mid low phase
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 5'd0, 1'b1);
        cyc(1'b0, 1'b1, 5'd0, 1'b1);
        e0 = n_drive;
        idle(20);
        check_int("R2", "drive after release", n_drive - e0, 0, 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule